// File: doc/BRIEF.md
# Masked Channel Change Event Detector

The block watches a vector of binary channel levels. Each time a new sample is strobed in, it compares the sample bit by bit with a stored baseline. For every channel that toggled and is currently enabled, it queues one event. Each event carries the channel index and whether the channel went high or low. Events drain one per handshake on a valid/ready output, lowest channel index first. After each capture the whole sample becomes the new baseline.

A per-channel enable mask, written as a full word, chooses which channels may report. When a mask write turns a channel on, that channel's baseline bit is first loaded from the level currently on the sample input, so turning a channel on never reports a stale edge. When a mask write turns a channel off, any event still queued for it is discarded. While events are still queued, the block raises a busy flag and does not take a new sample; the source holds its strobe until busy drops.

Top module: `chg_evt_detector`

## Requirements
- R1: After reset, `evtValid` and `sampleBusy` are low, every channel is enabled and the baseline is all zeros.
- R2: A sample is taken on a rising clock edge where `sampleValid` is high and `sampleBusy` is low. One event is queued for each enabled channel whose new bit differs from its baseline bit.
- R3: A sample equal to the baseline on all enabled channels queues nothing: `evtValid` and `sampleBusy` stay low.
- R4: A channel whose mask bit is 0 never produces an event.
- R5: `evtRising` is 1 when the channel's new level is 1, and 0 when the new level is 0.
- R6: Queued events leave in ascending channel order, one per edge with `evtValid` and `evtReady` both high. `evtChan` is the binary channel index.
- R7: While `evtReady` is low and no mask write occurs, `evtValid`, `evtChan` and `evtRising` hold their values.
- R8: `sampleBusy` is high while any event is queued. A sample offered then is not taken and leaves the baseline untouched. It is taken on the first edge after the queue empties, as long as the source still holds it.
- R9: After a capture, the baseline holds the whole new sample, so repeating that sample produces no events.
- R10: A mask write that sets a previously clear bit loads that channel's baseline bit from the current `sampleData` level.
- R11: A mask write that clears a bit discards any queued event for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | New sample offered |
| sampleData | input | NUM_CH | Channel levels |
| sampleBusy | output | 1 | Events queued; sample not taken |
| maskWrEn | input | 1 | Load enable mask |
| maskWrData | input | NUM_CH | New enable mask, bit i enables channel i |
| evtValid | output | 1 | Event available |
| evtReady | input | 1 | Consumer accepts event |
| evtChan | output | CH_W | Channel index of the event |
| evtRising | output | 1 | 1 = went high, 0 = went low |

## Verification
A corrupted baseline bit shows up on the next sample as a missing event or an extra one, or as an event with the wrong direction. It is therefore seen at the ports within one capture. A corrupted queue shows up within one handshake as an event out of order or a repeated event. A wrong busy flag shows up as a second sample captured over a queue that has not drained, which loses events in the next drain. The bench keeps its own baseline, mask and queue model and compares every visible event against the model on every cycle. The stimulus mixes random samples and random mask writes with back-pressure.

// File: rtl/chg_evt_pkg.sv
package chg_evt_pkg;
  typedef struct packed {
    logic capture;
    logic pop;
    logic maskLoad;
  } ctrl_strobes_t;
endpackage

// File: rtl/chg_evt_pick.sv
module chg_evt_pick #(
  parameter int W = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic [W-1:0]     oneHot,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign oneHot = vec & (~vec + W'(1));
  assign any    = |vec;
endmodule

// File: rtl/chg_evt_ctrl.sv
module chg_evt_ctrl
  import chg_evt_pkg::*;
(
  input  logic          sampleValid,
  input  logic          maskWrEn,
  input  logic          evtReady,
  input  logic          pendingAny,
  output ctrl_strobes_t st,
  output logic          sampleBusy
);
  always_comb begin
    st.capture  = sampleValid && !pendingAny;
    st.pop      = pendingAny && evtReady;
    st.maskLoad = maskWrEn;
  end

  assign sampleBusy = pendingAny;
endmodule

// File: rtl/chg_evt_datapath.sv
module chg_evt_datapath
  import chg_evt_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobes_t     st,
  input  logic [NUM_CH-1:0] sampleData,
  input  logic [NUM_CH-1:0] maskWrData,
  output logic              pendingAny,
  output logic [CH_W-1:0]   evtChan,
  output logic              evtRising
);
  logic [NUM_CH-1:0] prevReg, maskReg, pending;
  logic [NUM_CH-1:0] prevNext, maskNext, pendNext;
  logic [NUM_CH-1:0] selOneHot, turnOn;

  chg_evt_pick #(.W(NUM_CH), .IDX_W(CH_W)) u_pick (
    .vec(pending),
    .idx(evtChan),
    .oneHot(selOneHot),
    .any(pendingAny)
  );

  assign evtRising = prevReg[evtChan];
  assign turnOn    = maskWrData & ~maskReg;

  always_comb begin
    pendNext = pending;
    prevNext = prevReg;
    maskNext = maskReg;
    if (st.pop) pendNext = pendNext & ~selOneHot;
    if (st.capture) begin
      pendNext = (prevReg ^ sampleData) & maskReg;
      prevNext = sampleData;
    end
    if (st.maskLoad) begin
      pendNext = pendNext & maskWrData;
      prevNext = (prevNext & ~turnOn) | (sampleData & turnOn);
      maskNext = maskWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevReg <= '0;
      maskReg <= '1;
      pending <= '0;
    end else begin
      prevReg <= prevNext;
      maskReg <= maskNext;
      pending <= pendNext;
    end
  end

  AST_PEND_IN_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (pending & ~maskReg) == '0); // R4
  AST_ONE_PER_POP: assert property (@(posedge clk) disable iff (!rstN)
    st.pop && !st.maskLoad |=> $countones(pending) == $countones($past(pending)) - 1); // R6
  AST_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    st.pop |=> !pendingAny || (evtChan > $past(evtChan))); // R6
  AST_HOLD_EVT: assert property (@(posedge clk) disable iff (!rstN)
    pendingAny && !st.pop && !st.maskLoad |=> pendingAny && $stable(evtChan) && $stable(evtRising)); // R7
  AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    pendingAny && !st.maskLoad |=> $stable(prevReg)); // R8
  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    st.capture && !st.maskLoad |=> prevReg == $past(sampleData)); // R9
endmodule

// File: rtl/chg_evt_detector.sv
module chg_evt_detector
  import chg_evt_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [NUM_CH-1:0] sampleData,
  output logic              sampleBusy,
  input  logic              maskWrEn,
  input  logic [NUM_CH-1:0] maskWrData,
  output logic              evtValid,
  input  logic              evtReady,
  output logic [CH_W-1:0]   evtChan,
  output logic              evtRising
);
  ctrl_strobes_t st;
  logic pendingAny;

  chg_evt_ctrl u_ctrl (
    .sampleValid(sampleValid),
    .maskWrEn(maskWrEn),
    .evtReady(evtReady),
    .pendingAny(pendingAny),
    .st(st),
    .sampleBusy(sampleBusy)
  );

  chg_evt_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .st(st),
    .sampleData(sampleData),
    .maskWrData(maskWrData),
    .pendingAny(pendingAny),
    .evtChan(evtChan),
    .evtRising(evtRising)
  );

  assign evtValid = pendingAny;
endmodule

// File: tb/test_chg_evt_detector.sv
module test_chg_evt_detector;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 0, rstN = 0;
  logic sampleValid = 0, maskWrEn = 0, evtReady = 0;
  logic [N-1:0] sampleData = '0, maskWrData = '1;
  logic sampleBusy, evtValid, evtRising;
  logic [4:0] evtChan;

  int nChecks = 0, nFails = 0;
  logic [N-1:0] refPrev, refMask, expPend;

  chg_evt_detector #(.NUM_CH(N)) i_chg_evt_detector (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .sampleBusy(sampleBusy), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .evtValid(evtValid), .evtReady(evtReady), .evtChan(evtChan), .evtRising(evtRising)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  function automatic int lowestSet(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  // Offers a sample while idle: driven at a negedge, captured at the next posedge.
  task automatic sendSample(input logic [N-1:0] d);
    @(negedge clk);
    sampleData = d;
    sampleValid = 1;
    @(negedge clk);
    sampleValid = 0;
    expPend = (refPrev ^ d) & refMask;
    refPrev = d;
  endtask

  task automatic writeMask(input logic [N-1:0] m);
    logic [N-1:0] turnOn;
    @(negedge clk);
    maskWrEn = 1;
    maskWrData = m;
    @(negedge clk);
    maskWrEn = 0;
    turnOn = m & ~refMask;
    refPrev = (refPrev & ~turnOn) | (sampleData & turnOn);
    expPend = expPend & m;
    refMask = m;
  endtask

  // Starts at a negedge; consumes events with random back-pressure.
  task automatic drain(input int readyPct);
    int guard = 0;
    while (expPend != '0 && guard < 400) begin
      int idx = lowestSet(expPend);
      logic r;
      check(evtValid === 1'b1, "R2 evtValid", longint'(evtValid), 1);
      check(sampleBusy === 1'b1, "R8 busy while queued", longint'(sampleBusy), 1);
      check(evtChan === 5'(idx), "R6 channel order", longint'(evtChan), idx);
      check(evtRising === refPrev[idx], "R5 direction", longint'(evtRising), longint'(refPrev[idx]));
      r = (($urandom % 100) < readyPct);
      evtReady = r;
      if (r) expPend[idx] = 1'b0;
      @(negedge clk);
      guard++;
    end
    evtReady = 0;
    check(evtValid === 1'b0, "R2 queue empty", longint'(evtValid), 0);
    check(sampleBusy === 1'b0, "R8 busy clears", longint'(sampleBusy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    refPrev = '0; refMask = '1; expPend = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(evtValid === 1'b0, "R1 evtValid after reset", longint'(evtValid), 0);
    check(sampleBusy === 1'b0, "R1 busy after reset", longint'(sampleBusy), 0);

    // R1: all channels enabled, baseline zero -> all 32 rise
    sendSample('1);
    check(expPend == '1, "R1 model", longint'(expPend), 32'hffffffff);
    drain(100);

    // R3 / R9: repeat same sample -> nothing
    sendSample('1);
    check(evtValid === 1'b0, "R3 no change quiet", longint'(evtValid), 0);
    check(sampleBusy === 1'b0, "R9 baseline replaced", longint'(sampleBusy), 0);

    // R5: falling edges with back-pressure (R7)
    sendSample(32'h0F0F_F0F0);
    drain(30);

    // R4: disabled channels do not report
    writeMask(32'h0000_FFFF);
    sendSample(32'hF0F0_0F0F);
    drain(70);
    check(refMask == 32'h0000_FFFF, "R4 mask model", longint'(refMask), 32'h0000ffff);

    // R10: enabling loads baseline from live input (upper half differs from stored)
    @(negedge clk);
    sampleData = 32'h1234_0F0F;
    writeMask('1);
    sendSample(32'h1234_0F0F);
    check(evtValid === 1'b0, "R10 no spurious event", longint'(evtValid), 0);

    // R11: disabling a channel drops its queued event
    sendSample(32'h1234_0F0F ^ 32'h0000_0421);
    check(evtValid === 1'b1, "R11 queued", longint'(evtValid), 1);
    writeMask(~32'h0000_0020);
    drain(100);
    writeMask('1);

    // R8: sample held during drain is captured after it
    sendSample(32'h8000_0001 ^ refPrev);
    sampleData = refPrev ^ 32'h0000_0300;
    sampleValid = 1;
    drain(50);
    @(negedge clk);
    sampleValid = 0;
    expPend = (refPrev ^ sampleData) & refMask;
    refPrev = sampleData;
    check(expPend == 32'h0000_0300, "R8 held sample model", longint'(expPend), 32'h300);
    drain(100);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      int kind = $urandom % 10;
      if (kind < 2) begin
        logic [N-1:0] m = $urandom;
        if (kind == 0) m = '1;
        writeMask(m);
      end else if (kind < 5) begin
        sendSample($urandom);
        drain(60);
      end else begin
        logic [N-1:0] d = refPrev;
        d[$urandom % N] = ~d[$urandom % N];
        d[$urandom % N] = ~d[$urandom % N];
        sendSample(d);
        drain(80);
      end
    end

    summary();
    $finish;
  end
endmodule